// File: doc/BRIEF.md
# Variable-Width Register File Bridge

This block is a register bank behind an 8-bit register address. Each address holds 1 to 4 bytes, and the address range it falls in sets the count. A byte-serial host reaches the bank through already-framed strobes: a transfer marker, a direction flag, byte strobes and a stop marker. This is the data path an I2C-style target has once its pin layer has been stripped away.

A write transfer carries the register address first and then the data bytes, most significant byte first. The value is committed at the stop marker. The address byte of a write transfer also sets the read pointer. A following read transfer pulls bytes from the register the pointer selects, one byte per request.

Ranges of addresses are readable, writable or volatile. Volatile registers show live hardware status in place of stored data. A fixed identification word sits at the top of the map. A byte code written to one control address wipes the bank to its defaults and holds the block busy for a programmable number of cycles.

Top module: `vwr_bridge`

## Requirements
- R1: Register width follows the address. 4 bytes: 0x5C–0x6F, 0x98–0x9F, 0xC0–0xC3, 0xC8–0xCF, 0xDF–0xE5 and 0xF9. 3 bytes: 0x40–0x4F. 2 bytes: 0x30–0x35, 0x8C–0x97, 0xC4–0xC7 and 0xD7–0xDA. Every other address is 1 byte wide.
- R2: A read returns the register's bytes most significant byte first. Any request past the register's width returns 0x00.
- R3: A write commits only when the transfer carries at least as many data bytes as the register width. The first width bytes form the value, MSB first, and any further bytes are ignored. A transfer with too few bytes leaves the register unchanged.
- R4: The writable addresses are 0x00–0x1F, 0x21–0x2B, 0x30–0x35, 0x40–0x56 and 0x5C–0x76. A write to any other address is ignored. For example, 0x80 is readable but keeps reading 0x00, and 0x20 cannot be written.
- R5: The readable addresses are 0x00–0x2B, 0x30–0x35, 0x40–0x56, 0x5C–0x76, 0x80–0xAD, 0xB0–0xBA, 0xC0–0xE5 and 0xF0–0xFB. Every byte read from any other address is 0x00.
- R6: Address 0xF9 reads as the 32-bit word 0x00047000, which is vendor code 0x470 in bits 19:8. The bytes come out as 00, 04, 70, 00.
- R7: Writing 0x80 to address 0x03 clears every stored register to zero and stores nothing. `busy` then rises the next cycle and stays high for exactly RST_CYCLES cycles. While it is high, every host strobe is ignored. Any other value written to 0x03 is stored normally.
- R8: The volatile addresses are 0x0F–0x17, 0x20, 0xF0 and 0xF1. A read of one of them returns byte lane addr[1:0] of `hw_status`, where lane 0 is bits 7:0, and never the stored value.
- R9: `byte_out_vld` pulses for one cycle, the cycle after an accepted `byte_rd`, with `byte_out` valid alongside it. The register read is the one named by the address byte of the latest write transfer.
- R10: After reset, `busy` and `byte_out_vld` are low and every stored register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Transfer begins (repeated start allowed) |
| frm_read | input | 1 | Direction with frm_start: 1 read, 0 write |
| frm_stop | input | 1 | Transfer ends; a write commits here |
| byte_wr | input | 1 | Host byte strobe (address, then data) |
| byte_in | input | 8 | Host byte |
| byte_rd | input | 1 | Request for the next read byte |
| hw_status | input | 32 | Live status lanes for volatile registers |
| byte_out | output | 8 | Read byte |
| byte_out_vld | output | 1 | byte_out valid |
| busy | output | 1 | Soft reset in progress |

## Verification
The bench builds the bridge with RST_CYCLES set to 20, so each soft-reset window closes within a few dozen cycles. That makes two things reachable in one short run: measuring the exact length of the busy window, and sending a full write transfer inside it. The storage depth keeps its default of 128 words. This covers every writable address, so widths of one, two, three and four bytes can each be written and read back. The same default depth leaves the readable but unstored ranges above 0x7F to show the ignored-write case.

// File: rtl/vwr_pkg.sv
package vwr_pkg;

  typedef enum logic [1:0] {FS_IDLE, FS_ADDR, FS_DATA, FS_READ} fs_t;

  localparam logic [31:0] ID_WORD   = 32'h0004_7000;
  localparam logic [7:0]  ID_ADDR   = 8'hF9;
  localparam logic [7:0]  SRST_ADDR = 8'h03;
  localparam logic [7:0]  SRST_CODE = 8'h80;

  function automatic logic in_rng(input logic [7:0] a, input logic [7:0] lo,
                                  input logic [7:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [2:0] reg_bytes(input logic [7:0] a);
    if (in_rng(a, 8'h5C, 8'h6F) || in_rng(a, 8'h98, 8'h9F) || in_rng(a, 8'hC0, 8'hC3) ||
        in_rng(a, 8'hC8, 8'hCF) || in_rng(a, 8'hDF, 8'hE5) || a == ID_ADDR)
      return 3'd4;
    if (in_rng(a, 8'h40, 8'h4F))
      return 3'd3;
    if (in_rng(a, 8'h30, 8'h35) || in_rng(a, 8'h8C, 8'h97) || in_rng(a, 8'hC4, 8'hC7) ||
        in_rng(a, 8'hD7, 8'hDA))
      return 3'd2;
    return 3'd1;
  endfunction

  function automatic logic is_writable(input logic [7:0] a);
    return in_rng(a, 8'h00, 8'h1F) || in_rng(a, 8'h21, 8'h2B) || in_rng(a, 8'h30, 8'h35) ||
           in_rng(a, 8'h40, 8'h56) || in_rng(a, 8'h5C, 8'h76);
  endfunction

  function automatic logic is_readable(input logic [7:0] a);
    return in_rng(a, 8'h00, 8'h2B) || in_rng(a, 8'h30, 8'h35) || in_rng(a, 8'h40, 8'h56) ||
           in_rng(a, 8'h5C, 8'h76) || in_rng(a, 8'h80, 8'hAD) || in_rng(a, 8'hB0, 8'hBA) ||
           in_rng(a, 8'hC0, 8'hE5) || in_rng(a, 8'hF0, 8'hFB);
  endfunction

  function automatic logic is_volatile(input logic [7:0] a);
    return in_rng(a, 8'h0F, 8'h17) || a == 8'h20 || in_rng(a, 8'hF0, 8'hF1);
  endfunction

  // Byte k (0 = first on the wire) of an nb-byte value held right-aligned in w.
  function automatic logic [7:0] wire_byte(input logic [31:0] w, input logic [2:0] nb,
                                           input logic [2:0] k);
    logic [31:0] s;
    if (k >= nb) return 8'h00;
    s = w >> (8 * (int'(nb) - 1 - int'(k)));
    return s[7:0];
  endfunction

  function automatic logic [7:0] status_lane(input logic [31:0] st, input logic [1:0] ln);
    logic [31:0] s;
    s = st >> (8 * int'(ln));
    return s[7:0];
  endfunction

endpackage

// File: rtl/vwr_frontend.sv
module vwr_frontend
  import vwr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy,
  input  logic        frm_start,
  input  logic        frm_read,
  input  logic        frm_stop,
  input  logic        byte_wr,
  input  logic [7:0]  byte_in,
  input  logic        byte_rd,
  output logic [7:0]  ptr,
  output logic        rd_pick,
  output logic [2:0]  rd_idx,
  output logic        st_we,
  output logic [31:0] st_data,
  output logic        srst_go
);

  fs_t         state;
  logic [2:0]  wcnt;
  logic [31:0] acc;
  logic [2:0]  width;
  logic        commit;
  logic        srst_hit;

  assign width    = reg_bytes(ptr);
  assign commit   = !busy && (state == FS_DATA) && frm_stop && !frm_start && (wcnt == width);
  assign srst_hit = (ptr == SRST_ADDR) && (acc[7:0] == SRST_CODE);
  assign srst_go  = commit && srst_hit;
  assign st_we    = commit && !srst_hit && is_writable(ptr);
  assign st_data  = acc;
  assign rd_pick  = !busy && (state == FS_READ) && byte_rd && !frm_start && !frm_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FS_IDLE;
      ptr    <= '0;
      wcnt   <= '0;
      acc    <= '0;
      rd_idx <= '0;
    end else if (busy) begin
      state <= FS_IDLE;
    end else if (srst_go) begin
      state <= FS_IDLE;
      ptr   <= '0;
    end else if (frm_start) begin
      state  <= frm_read ? FS_READ : FS_ADDR;
      rd_idx <= '0;
    end else if (frm_stop) begin
      state <= FS_IDLE;
    end else begin
      case (state)
        FS_ADDR: if (byte_wr) begin
          ptr   <= byte_in;
          wcnt  <= '0;
          acc   <= '0;
          state <= FS_DATA;
        end
        FS_DATA: if (byte_wr && wcnt < width) begin
          acc  <= {acc[23:0], byte_in};
          wcnt <= wcnt + 3'd1;
        end
        FS_READ: if (byte_rd && rd_idx < 3'd4) rd_idx <= rd_idx + 3'd1;
        default: ;
      endcase
    end
  end

  assert_write_needs_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (wcnt == reg_bytes(ptr)) && frm_stop);

  assert_ro_never_stored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> is_writable(ptr));

  assert_idle_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> state == FS_IDLE);

endmodule

// File: rtl/vwr_store.sv
module vwr_store #(
  parameter int DEPTH      = 128,
  parameter int RST_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  input  logic        srst_go,
  output logic [31:0] rdata,
  output logic        busy
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [31:0]      mem [DEPTH];
  logic [CNT_W-1:0] rcnt;
  logic             in_span;

  assign in_span = int'(addr) < DEPTH;
  assign rdata   = in_span ? mem[addr[IDX_W-1:0]] : 32'h0;
  assign busy    = rcnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (srst_go) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && in_span) begin
      mem[addr[IDX_W-1:0]] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rcnt <= '0;
    else if (srst_go) rcnt <= CNT_W'(RST_CYCLES);
    else if (busy)    rcnt <= rcnt - 1'b1;
  end

  assert_busy_from_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(srst_go));

  assert_no_store_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !we && !srst_go);

  assert_wipe_after_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst_go) |-> rdata == 32'h0);

endmodule

// File: rtl/vwr_readout.sv
module vwr_readout
  import vwr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  ptr,
  input  logic        rd_pick,
  input  logic [2:0]  rd_idx,
  input  logic [31:0] stored,
  input  logic [31:0] hw_status,
  output logic [7:0]  byte_out,
  output logic        byte_out_vld
);

  logic [31:0] word;
  logic [2:0]  width;

  assign width = reg_bytes(ptr);

  always_comb begin
    if (!is_readable(ptr))     word = 32'h0;
    else if (ptr == ID_ADDR)   word = ID_WORD;
    else if (is_volatile(ptr)) word = {24'h0, status_lane(hw_status, ptr[1:0])};
    else                       word = stored;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_out     <= '0;
      byte_out_vld <= 1'b0;
    end else begin
      byte_out_vld <= rd_pick;
      if (rd_pick) byte_out <= wire_byte(word, width, rd_idx);
    end
  end

  assert_vld_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_out_vld |-> $past(rd_pick));

  assert_unreadable_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pick && !is_readable(ptr) |=> byte_out == 8'h00);

  assert_past_width_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pick && rd_idx >= width |=> byte_out == 8'h00);

  assert_id_vendor_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pick && ptr == ID_ADDR && rd_idx == 3'd1 |=> byte_out == 8'h04);

endmodule

// File: rtl/vwr_bridge.sv
module vwr_bridge #(
  parameter int DEPTH      = 128,
  parameter int RST_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frm_start,
  input  logic        frm_read,
  input  logic        frm_stop,
  input  logic        byte_wr,
  input  logic [7:0]  byte_in,
  input  logic        byte_rd,
  input  logic [31:0] hw_status,
  output logic [7:0]  byte_out,
  output logic        byte_out_vld,
  output logic        busy
);

  logic [7:0]  ptr;
  logic        rd_pick;
  logic [2:0]  rd_idx;
  logic        st_we;
  logic [31:0] st_data;
  logic        srst_go;
  logic [31:0] stored;

  vwr_frontend u_front (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .frm_start(frm_start), .frm_read(frm_read), .frm_stop(frm_stop),
    .byte_wr(byte_wr), .byte_in(byte_in), .byte_rd(byte_rd),
    .ptr(ptr), .rd_pick(rd_pick), .rd_idx(rd_idx),
    .st_we(st_we), .st_data(st_data), .srst_go(srst_go)
  );

  vwr_store #(.DEPTH(DEPTH), .RST_CYCLES(RST_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(st_we), .addr(ptr), .wdata(st_data),
    .srst_go(srst_go), .rdata(stored), .busy(busy)
  );

  vwr_readout u_read (
    .clk(clk), .rst_n(rst_n), .ptr(ptr), .rd_pick(rd_pick), .rd_idx(rd_idx),
    .stored(stored), .hw_status(hw_status),
    .byte_out(byte_out), .byte_out_vld(byte_out_vld)
  );

endmodule

// File: tb/sim_vwr_bridge.sv
module sim_vwr_bridge;

  localparam int TB_RST = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_start = 0, frm_read = 0, frm_stop = 0, byte_wr = 0, byte_rd = 0;
  logic [7:0]  byte_in = '0;
  logic [31:0] hw_status = 32'hDDCC_BBAA;
  logic [7:0]  byte_out;
  logic        byte_out_vld, busy;

  int n_run = 0, n_fail = 0;
  logic [7:0] rb [5];
  bit done = 0;

  always #4 clk = ~clk;

  vwr_bridge #(.RST_CYCLES(TB_RST)) u0 (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_read(frm_read),
    .frm_stop(frm_stop), .byte_wr(byte_wr), .byte_in(byte_in), .byte_rd(byte_rd),
    .hw_status(hw_status), .byte_out(byte_out), .byte_out_vld(byte_out_vld), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Write transfer: address byte then n data bytes from d (MSB first in d[0]).
  task automatic wr_xfer(input logic [7:0] a, input int n, input logic [7:0] d [5]);
    @(negedge clk); frm_start = 1; frm_read = 0;
    @(negedge clk); frm_start = 0; byte_wr = 1; byte_in = a;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_in = d[i];
    end
    @(negedge clk); byte_wr = 0; frm_stop = 1;
    @(negedge clk); frm_stop = 0;
  endtask

  // Point at a, then read n bytes into rb; every byte must come with byte_out_vld.
  task automatic rd_xfer(input logic [7:0] a, input int n);
    logic [7:0] none [5];
    wr_xfer(a, 0, none);
    @(negedge clk); frm_start = 1; frm_read = 1;
    @(negedge clk); frm_start = 0;
    for (int i = 0; i < n; i++) begin
      byte_rd = 1;
      @(negedge clk); byte_rd = 0;
      chk("R9 vld", {31'b0, byte_out_vld}, 32'd1);
      rb[i] = byte_out;
      @(negedge clk);
      chk("R9 vld one cycle", {31'b0, byte_out_vld}, 32'd0);
    end
    frm_stop = 1;
    @(negedge clk); frm_stop = 0;
  endtask

  function automatic logic [31:0] pack4();
    return {rb[0], rb[1], rb[2], rb[3]};
  endfunction

  task automatic t_reset();
    chk("R10 busy", {31'b0, busy}, 0);
    chk("R10 vld", {31'b0, byte_out_vld}, 0);
    rd_xfer(8'h45, 3);
    chk("R10 zero 0x45", {8'h0, rb[0], rb[1], rb[2]}, 0);
  endtask

  task automatic t_widths();
    logic [7:0] d [5] = '{8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE};
    wr_xfer(8'h45, 3, d); rd_xfer(8'h45, 4);
    chk("R1 R2 3B 0x45", pack4(), 32'hAABBCC00);
    d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    wr_xfer(8'h5C, 4, d); rd_xfer(8'h5C, 4);
    chk("R1 R2 4B 0x5C", pack4(), 32'h11223344);
    d = '{8'h9A, 8'hBC, 8'hDE, 8'h00, 8'h00};
    wr_xfer(8'h31, 3, d); rd_xfer(8'h31, 3);
    chk("R3 extra ignored 0x31", {8'h0, rb[0], rb[1], rb[2]}, 32'h009ABC00);
    d = '{8'h5E, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_xfer(8'h00, 1, d); rd_xfer(8'h00, 2);
    chk("R1 1B 0x00", {16'h0, rb[0], rb[1]}, 32'h00005E00);
  endtask

  task automatic t_short();
    logic [7:0] d [5] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    wr_xfer(8'h45, 2, d); rd_xfer(8'h45, 3);
    chk("R3 short write 0x45", {8'h0, rb[0], rb[1], rb[2]}, 32'h00AABBCC);
  endtask

  task automatic t_access();
    logic [7:0] d [5] = '{8'h55, 8'h66, 8'h77, 8'h88, 8'h99};
    wr_xfer(8'h80, 1, d); rd_xfer(8'h80, 1);
    chk("R4 ro 0x80", {24'h0, rb[0]}, 0);
    rd_xfer(8'h36, 1);
    chk("R5 unreadable 0x36", {24'h0, rb[0]}, 0);
    wr_xfer(8'h2C, 1, d); rd_xfer(8'h2C, 1);
    chk("R5 unreadable 0x2C", {24'h0, rb[0]}, 0);
    rd_xfer(8'hF9, 4);
    chk("R6 id 0xF9", pack4(), 32'h00047000);
  endtask

  task automatic t_volatile();
    logic [7:0] d [5] = '{8'h77, 8'h00, 8'h00, 8'h00, 8'h00};
    rd_xfer(8'h0F, 1); chk("R8 0x0F lane3", {24'h0, rb[0]}, 32'hDD);
    wr_xfer(8'h10, 1, d); rd_xfer(8'h10, 1);
    chk("R8 0x10 live not stored", {24'h0, rb[0]}, 32'hAA);
    rd_xfer(8'hF1, 1); chk("R8 0xF1 lane1", {24'h0, rb[0]}, 32'hBB);
    wr_xfer(8'h20, 1, d); rd_xfer(8'h20, 1);
    chk("R4 R8 0x20", {24'h0, rb[0]}, 32'hAA);
    hw_status = 32'h1234_5678;
    rd_xfer(8'h16, 1); chk("R8 0x16 lane2", {24'h0, rb[0]}, 32'h34);
  endtask

  task automatic t_softreset();
    logic [7:0] d [5] = '{8'h81, 8'h00, 8'h00, 8'h00, 8'h00};
    int n;
    wr_xfer(8'h03, 1, d); rd_xfer(8'h03, 1);
    chk("R7 other code stored", {24'h0, rb[0]}, 32'h81);
    chk("R7 no busy on 0x81", {31'b0, busy}, 0);
    d[0] = 8'h80;
    wr_xfer(8'h03, 1, d);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk("R7 busy length", n, TB_RST);
    rd_xfer(8'h45, 3);
    chk("R7 wiped 0x45", {8'h0, rb[0], rb[1], rb[2]}, 0);
    rd_xfer(8'h03, 1);
    chk("R7 code not stored", {24'h0, rb[0]}, 0);
    wr_xfer(8'h03, 1, d);
    chk("R7 busy rises", {31'b0, busy}, 1);
    d[0] = 8'h5A;
    wr_xfer(8'h00, 1, d);
    while (busy) @(negedge clk);
    rd_xfer(8'h00, 1);
    chk("R7 write during busy ignored", {24'h0, rb[0]}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_widths();
    t_short();
    t_access();
    t_volatile();
    t_softreset();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule